// File: doc/BRIEF.md
# Watchdog Port Mode Fallback Controller

This block guards the operating modes of a four-port power controller. The host programs a reload value, and the block counts it down on each timebase tick while the watchdog is enabled. If the host stops refreshing the count and it reaches zero, the block does not reset the system. Instead it moves each port into a safe mode chosen per port: automatic (code 11) or shutdown (code 00).

On that expiry the block also sets a sticky status flag for every port. It can then raise a level interrupt, gated by an interrupt-enable bit. All state is reached through a small register bus with single-cycle writes and registered reads. Outside a fallback event the host sets each port's 2-bit mode directly.

Top module: `wdfb_top`

## Requirements
- R1: After reset, the control register reads 00h, all mode fields are 00, the status flags read 0, the counter reads 0 and `irq` is low.
- R2: The control register sits at address 1Fh. Its bits 5 and 4 always read 0 and ignore writes. Bits 7, 6 and 3..0 read back what was written, one cycle after the read address is presented.
- R3: The counter decrements by one per `tick` only while control bit 7 (enable) is 1. While the enable bit is 0 the count is frozen, and no fallback or flag update occurs.
- R4: A write to address 20h loads the counter with the written value, and a read of 20h returns the live count. A load in the same cycle as a `tick` takes the loaded value.
- R5: In the cycle the count steps from 1 to 0 with enable set, every port whose fallback bit is 0 gets mode 00. The fallback bit for port n is control bit n-1.
- R6: In that same cycle, every port whose fallback bit is 1 gets mode 11. The mode of port n sits on `port_mode[2n-1:2n-2]`, and also in the same bits of the mode register at 12h.
- R7: The count holds at 0 once expired, and no further forcing happens until the counter has been reloaded and expires again. Mode writes after an expiry stick.
- R8: On expiry all four status flags (address 21h, bit n-1 for port n) are set. They stay set until the host writes a 1 to them. If an expiry and a clearing write fall in the same cycle, the flags end up set.
- R9: `irq` equals control bit 6 ANDed with the OR of the status flags. It changes on the same clock edge as those registers.
- R10: A host write to the mode register in the expiry cycle loses to the forced fallback modes.
- R11: Outside an expiry cycle, a write to the mode register at 12h sets all port modes to the written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register address for reads and writes |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data for the address of the previous cycle |
| tick | input | 1 | Timebase tick, one cycle wide |
| port_mode | output | 8 | Four 2-bit port modes, port 1 in the low bits |
| irq | output | 1 | Level interrupt |

## Verification
The expiry can fall in the same cycle as a host write. The bench provokes this by loading a count of 1 and then, in one cycle, raising `tick` together with a bus write. In one run the write targets the mode register and must lose to the forced modes. In the other it writes ones to the flags and must leave them set. A third collision pairs a reload write with a tick, and the loaded value must win. Each outcome is judged by reading the port outputs and the registers on the following cycle.

// File: rtl/wdfb_pkg.sv
package wdfb_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;
  localparam int MODE_W = 2;

  localparam logic [ADDR_W-1:0] A_MODE   = 8'h12;
  localparam logic [ADDR_W-1:0] A_CTRL   = 8'h1F;
  localparam logic [ADDR_W-1:0] A_RELOAD = 8'h20;
  localparam logic [ADDR_W-1:0] A_FLAGS  = 8'h21;

  localparam int B_EN  = 7;
  localparam int B_IEN = 6;

  typedef enum logic [MODE_W-1:0] {
    MODE_OFF  = 2'b00,
    MODE_SEMI = 2'b01,
    MODE_MAN  = 2'b10,
    MODE_AUTO = 2'b11
  } port_mode_e;
endpackage

// File: rtl/wdfb_counter.sv
module wdfb_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] count_q;

  assign expire = run & tick & ~load & (count_q == ONE);
  assign count  = count_q;

  always_ff @(posedge clk) begin
    if (rst)
      count_q <= '0;
    else if (load)
      count_q <= load_val;
    else if (run && tick && count_q != '0)
      count_q <= count_q - ONE;
  end

  // R3
  frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !load) |=> $stable(count_q));

  // R4
  load_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (count_q == $past(load_val)));

  // R7
  hold_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (count_q == '0 && !load) |=> (count_q == '0));
endmodule

// File: rtl/wdfb_mode_bank.sv
module wdfb_mode_bank
  import wdfb_pkg::*;
#(
  parameter int NPORTS = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     expire,
  input  logic [NPORTS-1:0]        fallback,
  input  logic                     wr_mode,
  input  logic [NPORTS*MODE_W-1:0] wr_val,
  output logic [NPORTS*MODE_W-1:0] modes
);
  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    port_mode_e mode_q;

    always_ff @(posedge clk) begin
      if (rst)
        mode_q <= MODE_OFF;
      else if (expire)
        mode_q <= fallback[p] ? MODE_AUTO : MODE_OFF;
      else if (wr_mode)
        mode_q <= port_mode_e'(wr_val[p*MODE_W +: MODE_W]);
    end

    assign modes[p*MODE_W +: MODE_W] = mode_q;

    // R5
    force_off_chk: assert property (@(posedge clk) disable iff (rst)
      (expire && !fallback[p]) |=> (mode_q == MODE_OFF));

    // R6
    force_auto_chk: assert property (@(posedge clk) disable iff (rst)
      (expire && fallback[p]) |=> (mode_q == MODE_AUTO));

    // R11
    host_write_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_mode && !expire) |=> (mode_q == $past(wr_val[p*MODE_W +: MODE_W])));
  end
endmodule

// File: rtl/wdfb_regs.sv
module wdfb_regs
  import wdfb_pkg::*;
#(
  parameter int NPORTS = 4,
  parameter int CNT_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic                     bus_wr,
  input  logic [DATA_W-1:0]        bus_wdata,
  input  logic                     expire,
  input  logic [CNT_W-1:0]         count,
  input  logic [NPORTS*MODE_W-1:0] modes,
  output logic [DATA_W-1:0]        rdata,
  output logic                     wd_en,
  output logic [NPORTS-1:0]        fallback,
  output logic                     irq
);
  localparam logic [DATA_W-1:0] PORT_MASK = DATA_W'((1 << NPORTS) - 1);
  localparam logic [DATA_W-1:0] CTRL_MASK =
    DATA_W'((1 << B_EN) | (1 << B_IEN)) | PORT_MASK;

  logic [DATA_W-1:0] ctrl_q, ctrl_d;
  logic [NPORTS-1:0] flags_q, flags_d;
  logic [DATA_W-1:0] rdata_q, rmux;
  logic              irq_q;
  logic              wr_ctrl, wr_flags;

  assign wr_ctrl  = bus_wr && bus_addr == A_CTRL;
  assign wr_flags = bus_wr && bus_addr == A_FLAGS;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl)
      ctrl_d = bus_wdata & CTRL_MASK;
  end

  always_comb begin
    flags_d = flags_q;
    if (wr_flags)
      flags_d = flags_q & ~bus_wdata[NPORTS-1:0];
    if (expire)
      flags_d = '1;
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:   rmux = ctrl_q;
      A_MODE:   rmux = DATA_W'(modes);
      A_RELOAD: rmux = DATA_W'(count);
      A_FLAGS:  rmux = DATA_W'(flags_q);
      default:  rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      flags_q <= '0;
      irq_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      flags_q <= flags_d;
      irq_q   <= ctrl_d[B_IEN] & (|flags_d);
      rdata_q <= rmux;
    end
  end

  assign rdata    = rdata_q;
  assign wd_en    = ctrl_q[B_EN];
  assign fallback = ctrl_q[NPORTS-1:0];
  assign irq      = irq_q;

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[5:4] == 2'b00));

  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (|($past(flags_q) & ~flags_q)) |-> $past(wr_flags));

  // R8
  flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    expire |=> (&flags_q));

  // R9
  irq_raise_chk: assert property (@(posedge clk) disable iff (rst)
    (expire && ctrl_d[B_IEN]) |=> irq_q);
endmodule

// File: rtl/wdfb_top.sv
module wdfb_top
  import wdfb_pkg::*;
#(
  parameter int NPORTS = 4,
  parameter int CNT_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic                     bus_wr,
  input  logic [DATA_W-1:0]        bus_wdata,
  output logic [DATA_W-1:0]        bus_rdata,
  input  logic                     tick,
  output logic [NPORTS*MODE_W-1:0] port_mode,
  output logic                     irq
);
  logic             wd_en, expire, load, wr_mode;
  logic [NPORTS-1:0] fallback;
  logic [CNT_W-1:0]  count;

  assign load    = bus_wr && bus_addr == A_RELOAD;
  assign wr_mode = bus_wr && bus_addr == A_MODE;

  wdfb_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .run(wd_en), .tick(tick), .load(load),
    .load_val(bus_wdata[CNT_W-1:0]), .count(count), .expire(expire)
  );

  wdfb_mode_bank #(.NPORTS(NPORTS)) u_modes (
    .clk(clk), .rst(rst), .expire(expire), .fallback(fallback),
    .wr_mode(wr_mode), .wr_val(bus_wdata[NPORTS*MODE_W-1:0]),
    .modes(port_mode)
  );

  wdfb_regs #(.NPORTS(NPORTS), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .expire(expire), .count(count),
    .modes(port_mode), .rdata(bus_rdata), .wd_en(wd_en),
    .fallback(fallback), .irq(irq)
  );

  // R3
  no_expire_disabled_chk: assert property (@(posedge clk) disable iff (rst)
    !wd_en |-> !expire);
endmodule

// File: tb/tb_wdfb_top.sv
module tb_wdfb_top;
  logic       clk = 0, rst = 1, bus_wr = 0, tick = 0;
  logic [7:0] bus_addr = 0, bus_wdata = 0;
  logic [7:0] bus_rdata, port_mode;
  logic       irq;
  int         n_chk = 0, n_fail = 0;
  logic [7:0] r;

  // {fallback bits, expected modes after expiry}
  localparam logic [11:0] VEC [6] = '{
    12'h0_00, 12'hF_FF, 12'h1_03, 12'h8_C0, 12'h5_33, 12'hA_CC
  };

  wdfb_top dut (.*);

  always #10 clk = ~clk;

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d, logic with_tick = 0);
    bus_addr = a; bus_wdata = d; bus_wr = 1; tick = with_tick;
    @(negedge clk);
    bus_wr = 0; tick = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic pulse(int n);
    for (int k = 0; k < n; k++) begin
      tick = 1; @(negedge clk); tick = 0;
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog timeout actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    rd(8'h1F, r); chk("R1 ctrl", r, 8'h00);
    rd(8'h21, r); chk("R1 flags", r, 8'h00);
    rd(8'h20, r); chk("R1 count", r, 8'h00);
    chk("R1 modes", port_mode, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);

    // R2 reserved bits
    wr(8'h1F, 8'hFF);
    rd(8'h1F, r); chk("R2 ctrl readback", r, 8'hCF);
    wr(8'h1F, 8'h00);

    // vector table: R5 R6 R8 R11
    for (int i = 0; i < 6; i++) begin
      wr(8'h1F, {4'h8, VEC[i][11:8]});
      wr(8'h12, 8'h55);
      chk("R11 host mode write", port_mode, 8'h55);
      wr(8'h20, 8'd2);
      pulse(1);
      chk("R11 before expiry", port_mode, 8'h55);
      pulse(1);
      chk("R5/R6 fallback modes", port_mode, VEC[i][7:0]);
      rd(8'h12, r); chk("R6 mode register", r, VEC[i][7:0]);
      rd(8'h21, r); chk("R8 flags set", r, 8'h0F);
      chk("R9 irq masked", {7'd0, irq}, 8'h00);
      wr(8'h21, 8'h0F);
      rd(8'h21, r); chk("R8 flags cleared", r, 8'h00);
    end

    // R3 disabled: frozen, no fallback
    wr(8'h1F, 8'h0F);
    wr(8'h12, 8'h66);
    wr(8'h20, 8'd3);
    pulse(5);
    rd(8'h20, r); chk("R3 frozen count", r, 8'd3);
    chk("R3 no fallback", port_mode, 8'h66);
    rd(8'h21, r); chk("R3 no flags", r, 8'h00);

    // R3 enabled: one decrement per tick
    wr(8'h1F, 8'h80);
    pulse(2);
    rd(8'h20, r); chk("R3 decrement", r, 8'd1);

    // R4 load beats tick
    wr(8'h20, 8'd5, 1);
    rd(8'h20, r); chk("R4 load wins over tick", r, 8'd5);

    // R7 hold at zero, no re-forcing
    pulse(5);
    chk("R7 expiry modes", port_mode, 8'h00);
    wr(8'h21, 8'h0F);
    wr(8'h12, 8'h99);
    pulse(4);
    rd(8'h20, r); chk("R7 count holds zero", r, 8'd0);
    chk("R7 no re-forcing", port_mode, 8'h99);
    rd(8'h21, r); chk("R7 no new flags", r, 8'h00);

    // R9 irq follows enable and flags
    wr(8'h1F, 8'hC0);
    wr(8'h20, 8'd1);
    pulse(1);
    chk("R9 irq raised", {7'd0, irq}, 8'h01);
    wr(8'h1F, 8'h80);
    chk("R9 irq masked", {7'd0, irq}, 8'h00);
    rd(8'h21, r); chk("R9 flags kept", r, 8'h0F);
    wr(8'h1F, 8'hC0);
    chk("R9 irq re-enabled", {7'd0, irq}, 8'h01);
    wr(8'h21, 8'h0F);
    chk("R9 irq drops on clear", {7'd0, irq}, 8'h00);

    // R8 expiry beats clearing write
    wr(8'h1F, 8'h80);
    wr(8'h12, 8'hAA);
    wr(8'h20, 8'd1);
    wr(8'h21, 8'h0F, 1);
    rd(8'h21, r); chk("R8 set beats clear", r, 8'h0F);
    chk("R5 collision modes", port_mode, 8'h00);
    wr(8'h21, 8'h0F);

    // R10 expiry beats host mode write
    wr(8'h1F, 8'h8F);
    wr(8'h20, 8'd1);
    wr(8'h12, 8'h00, 1);
    chk("R10 forced over host write", port_mode, 8'hFF);

    finish_run();
  end
endmodule